// File: doc/BRIEF.md
# Power-Management Event Status and Wake Routing

This block holds a 16-bit power-management event status register and a matching enable register. It latches events from a timer-overflow input, a global-event input, the power button and a real-time-clock alarm. It decides whether a latched event should wake a sleeping system. When the system is running, it drives either a system-control interrupt (SCI) or a system-management interrupt (SMI#) level. A routing input selects which of the two is used.

The block also tracks a coarse system state: running, sleeping, or soft-off. A one-cycle sleep strobe moves the system from running to sleeping. A new enabled event returns it to running and records that a wake happened. Holding the power button long enough forces soft-off, whatever the current state.

The status bits sit in three reset domains: core, resume and real-time clock. Each domain is cleared by its own active-low synchronous reset. A deeper reset also clears every shallower domain. This lets a warm restart, a power loss and a clock-battery loss each keep the right set of bits.

Top module: `pmev_top`

## Requirements
- R1: After all three resets are released, the status register reads 0000h, the enable register reads 0000h, `sysState` is 0 (running), and `sciOut`, `smiOut` and `wakeEvent` are low.
- R2: Writing the status register (`regAddr`=0) clears each bit written as 1 and leaves bits written as 0 untouched. If a hardware set and a write-one-clear hit the same bit on the same edge, the bit stays set.
- R3: The status bits are set as follows. Bit 0 is set on any edge where `tmrOvf` is high. Bit 5 is set on any edge where `gblEvt` is high. Bit 8 is set on a rising edge of `pwrBtn`. Bit 10 is set on a rising edge of `rtcAlarm`.
- R4: In the enable register (`regAddr`=1), only bits 0, 5, 8 and 10 (each enabling the status bit at the same position) and bit 14 (the after-power-loss flag) are writable. Every other bit of either register reads 0.
- R5: While running, `sciOut` is high when `sciEnable`=1 and any of status bits 0, 5, 8 or 10 is set together with its enable. `smiOut` is high when `sciEnable`=0 and any of bits 0, 8 or 10 is set together with its enable. Bit 5 never raises `smiOut`. Both outputs are levels that fall when the bits are cleared.
- R6: A `sleepReq` pulse while running moves `sysState` to 1 (sleeping). While `sysState` is not 0, `sciOut` and `smiOut` stay low.
- R7: While sleeping (state 1) or soft-off (state 2), a rising edge of `pwrBtn` with enable bit 8 set, or of `rtcAlarm` with enable bit 10 set, raises `wakeEvent` in that cycle. On the following edge, status bit 15 is set and `sysState` returns to 0. An event whose enable is clear sets its status bit but causes no wake.
- R8: When `pwrBtn` has been high on HOLD_CYCLES consecutive edges, that edge sets status bit 11, forces `sysState` to 2 (soft-off) and sets enable bit 14. A release before then restarts the count.
- R9: A core reset alone (`coreRstN` low) clears status bits 0 and 5 and enable bits 0 and 5. It keeps status bits 8, 10, 11 and 15, enable bits 8, 10 and 14, and `sysState`.
- R10: A resume reset clears status bits 0, 5, 8, 10 and 15 and enable bits 0, 5, 8 and 10. It keeps status bit 11 and enable bit 14. On release, `sysState` is 2 if enable bit 14 was set and 0 otherwise, and status bit 15 is not set. A later enabled wake from that state sets bit 15.
- R11: A real-time-clock reset (`rtcRstN` low) clears every status and enable bit, including bits 11 and 14, and returns `sysState` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| coreRstN | input | 1 | Core-domain synchronous reset, active low |
| resumeRstN | input | 1 | Resume-domain synchronous reset, active low; also resets the core domain |
| rtcRstN | input | 1 | Clock-battery-domain synchronous reset, active low; also resets resume and core |
| tmrOvf | input | 1 | Timer overflow event |
| gblEvt | input | 1 | Global event |
| pwrBtn | input | 1 | Power button level, high while pressed |
| rtcAlarm | input | 1 | Real-time-clock alarm level |
| sleepReq | input | 1 | One-cycle strobe that enters the sleeping state |
| sciEnable | input | 1 | 1 routes events to SCI, 0 routes them to SMI# |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the status register, 1 selects the enable register |
| regWData | input | 16 | Write data |
| regRData | output | 16 | Read data of the selected register |
| sciOut | output | 1 | SCI level |
| smiOut | output | 1 | SMI# level (active-high here) |
| wakeEvent | output | 1 | High in the cycle a qualified wake event is seen |
| sysState | output | 2 | 0 running, 1 sleeping, 2 soft-off |

## Verification
A status bit held in the wrong domain shows up in the read data on the first read after a reset pulse: the bit is either still set or already lost. A wrong routing or enable term shows on `sciOut` or `smiOut` in the same cycle the routing input or a status bit changes. A faulty wake or override path shows as `sysState` staying put, or bit 15 or bit 11 staying clear, one edge after `wakeEvent` or after the last held button edge. So every stored error becomes visible at the ports within one or two cycles of the stimulus that exposes it.

// File: rtl/pmev_pkg.sv
package pmev_pkg;

  typedef enum logic [1:0] {
    PWR_ON    = 2'b00,
    PWR_SLEEP = 2'b01,
    PWR_OFF   = 2'b10
  } pwrState_e;

  // status bit cells: index -> bit position and reset domain
  localparam int N_STS = 6;
  localparam int IDX_TMR = 0;
  localparam int IDX_GBL = 1;
  localparam int IDX_BTN = 2;
  localparam int IDX_RTC = 3;
  localparam int IDX_OVR = 4;
  localparam int IDX_WAK = 5;

  localparam int POS_TMR = 0;
  localparam int POS_GBL = 5;
  localparam int POS_BTN = 8;
  localparam int POS_RTC = 10;
  localparam int POS_OVR = 11;
  localparam int POS_WAK = 15;
  localparam int POS_AFTERLOSS = 14;

  localparam int DOM_CORE = 0;
  localparam int DOM_RES  = 1;
  localparam int DOM_RTC  = 2;
  localparam int N_DOM    = 3;

  localparam int STS_POS [N_STS] = '{POS_TMR, POS_GBL, POS_BTN, POS_RTC, POS_OVR, POS_WAK};
  localparam int STS_DOM [N_STS] = '{DOM_CORE, DOM_CORE, DOM_RES, DOM_RES, DOM_RTC, DOM_RES};

  // strobes from control to datapath
  typedef struct packed {
    logic setWake;
    logic setOvr;
  } ctlStrobe_t;

endpackage

// File: rtl/pmev_w1c_bit.sv
module pmev_w1c_bit (
  input  logic clk,
  input  logic clr,
  input  logic set,
  input  logic wipe,
  output logic q
);
  // set beats write-one-clear so no event is lost
  always_ff @(posedge clk) begin
    if (clr)       q <= 1'b0;
    else if (set)  q <= 1'b1;
    else if (wipe) q <= 1'b0;
  end
endmodule

// File: rtl/pmev_datapath.sv
module pmev_datapath
  import pmev_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             coreRstN,
  input  logic             resumeRstN,
  input  logic             rtcRstN,
  input  logic             tmrOvf,
  input  logic             gblEvt,
  input  logic             pwrBtn,
  input  logic             rtcAlarm,
  input  logic             sciEnable,
  input  logic             inS0,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWData,
  input  ctlStrobe_t       strobe,
  output logic [REG_W-1:0] regRData,
  output logic [REG_W-1:0] statusVec,
  output logic             sciOut,
  output logic             smiOut,
  output logic             wakeCand,
  output logic             afterLoss
);

  logic rtcClr, resClr, coreClr;
  logic [N_DOM-1:0] domClr;
  assign rtcClr  = !rtcRstN;
  assign resClr  = !resumeRstN || rtcClr;
  assign coreClr = !coreRstN || resClr;
  assign domClr[DOM_CORE] = coreClr;
  assign domClr[DOM_RES]  = resClr;
  assign domClr[DOM_RTC]  = rtcClr;

  // edge detection on button and alarm
  logic btnQ, rtcQ, btnEdge, rtcEdge;
  always_ff @(posedge clk) begin
    if (coreClr) begin
      btnQ <= 1'b0;
      rtcQ <= 1'b0;
    end else begin
      btnQ <= pwrBtn;
      rtcQ <= rtcAlarm;
    end
  end
  assign btnEdge = pwrBtn && !btnQ;
  assign rtcEdge = rtcAlarm && !rtcQ;

  logic stsWr, enWr;
  assign stsWr = regWr && !regAddr;
  assign enWr  = regWr && regAddr;

  // status cells
  logic [N_STS-1:0] setVec, stsQ;
  always_comb begin
    setVec = '0;
    setVec[IDX_TMR] = tmrOvf;
    setVec[IDX_GBL] = gblEvt;
    setVec[IDX_BTN] = btnEdge;
    setVec[IDX_RTC] = rtcEdge;
    setVec[IDX_OVR] = strobe.setOvr;
    setVec[IDX_WAK] = strobe.setWake;
  end

  for (genvar i = 0; i < N_STS; i++) begin : g_sts
    pmev_w1c_bit u_bit (
      .clk  (clk),
      .clr  (domClr[STS_DOM[i]]),
      .set  (setVec[i]),
      .wipe (stsWr && regWData[STS_POS[i]]),
      .q    (stsQ[i])
    );
  end

  always_comb begin
    statusVec = '0;
    for (int i = 0; i < N_STS; i++) statusVec[STS_POS[i]] = stsQ[i];
  end

  // enable bits
  logic enTmr, enGbl, enBtn, enRtc;
  always_ff @(posedge clk) begin
    if (coreClr) begin
      enTmr <= 1'b0;
      enGbl <= 1'b0;
    end else if (enWr) begin
      enTmr <= regWData[POS_TMR];
      enGbl <= regWData[POS_GBL];
    end
  end

  always_ff @(posedge clk) begin
    if (resClr) begin
      enBtn <= 1'b0;
      enRtc <= 1'b0;
    end else if (enWr) begin
      enBtn <= regWData[POS_BTN];
      enRtc <= regWData[POS_RTC];
    end
  end

  always_ff @(posedge clk) begin
    if (rtcClr)             afterLoss <= 1'b0;
    else if (strobe.setOvr) afterLoss <= 1'b1;
    else if (enWr)          afterLoss <= regWData[POS_AFTERLOSS];
  end

  logic [REG_W-1:0] enVec;
  always_comb begin
    enVec = '0;
    enVec[POS_TMR]       = enTmr;
    enVec[POS_GBL]       = enGbl;
    enVec[POS_BTN]       = enBtn;
    enVec[POS_RTC]       = enRtc;
    enVec[POS_AFTERLOSS] = afterLoss;
  end

  assign regRData = regAddr ? enVec : statusVec;

  // interrupt routing
  logic tmrHit, gblHit, btnHit, rtcHit, sciSrc, smiSrc;
  assign tmrHit = stsQ[IDX_TMR] && enTmr;
  assign gblHit = stsQ[IDX_GBL] && enGbl;
  assign btnHit = stsQ[IDX_BTN] && enBtn;
  assign rtcHit = stsQ[IDX_RTC] && enRtc;
  assign sciSrc = tmrHit || gblHit || btnHit || rtcHit;
  assign smiSrc = tmrHit || btnHit || rtcHit;
  assign sciOut = inS0 && sciEnable && sciSrc;
  assign smiOut = inS0 && !sciEnable && smiSrc;

  // a fresh enabled event is a wake candidate
  assign wakeCand = (btnEdge && enBtn) || (rtcEdge && enRtc);

  logic unusedWrBits;
  assign unusedWrBits = ^regWData;

endmodule

// File: rtl/pmev_ctrl.sv
module pmev_ctrl
  import pmev_pkg::*;
#(
  parameter int HOLD_CYCLES = 64
) (
  input  logic       clk,
  input  logic       resumeRstN,
  input  logic       rtcRstN,
  input  logic       pwrBtn,
  input  logic       sleepReq,
  input  logic       wakeCand,
  input  logic       afterLoss,
  output ctlStrobe_t strobe,
  output pwrState_e  state,
  output logic       wakeEvent
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HOLD_CYCLES);

  logic resClr;
  assign resClr = !resumeRstN || !rtcRstN;

  // button hold counter, saturating, restarts on release
  logic [CNT_W-1:0] holdCnt;
  logic ovrFire;
  always_ff @(posedge clk) begin
    if (resClr || !pwrBtn)      holdCnt <= '0;
    else if (holdCnt != CNT_FULL) holdCnt <= holdCnt + 1'b1;
  end
  assign ovrFire = pwrBtn && (holdCnt == CNT_LAST);

  logic sleeping;
  assign sleeping  = (state != PWR_ON);
  assign wakeEvent = sleeping && wakeCand && !ovrFire;

  always_ff @(posedge clk) begin
    if (!rtcRstN)                         state <= PWR_ON;
    else if (!resumeRstN)                 state <= afterLoss ? PWR_OFF : PWR_ON;
    else if (ovrFire)                     state <= PWR_OFF;
    else if (wakeEvent)                   state <= PWR_ON;
    else if (sleepReq && state == PWR_ON) state <= PWR_SLEEP;
  end

  always_comb begin
    strobe.setOvr  = ovrFire;
    strobe.setWake = wakeEvent;
  end

endmodule

// File: rtl/pmev_top.sv
module pmev_top
  import pmev_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int HOLD_CYCLES = 64
) (
  input  logic             clk,
  input  logic             coreRstN,
  input  logic             resumeRstN,
  input  logic             rtcRstN,
  input  logic             tmrOvf,
  input  logic             gblEvt,
  input  logic             pwrBtn,
  input  logic             rtcAlarm,
  input  logic             sleepReq,
  input  logic             sciEnable,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWData,
  output logic [REG_W-1:0] regRData,
  output logic             sciOut,
  output logic             smiOut,
  output logic             wakeEvent,
  output logic [1:0]       sysState
);

  ctlStrobe_t       strobe;
  pwrState_e        state;
  logic             wakeCand;
  logic             afterLoss;
  logic [REG_W-1:0] statusVec;

  pmev_datapath #(.REG_W(REG_W)) u_dp (
    .clk        (clk),
    .coreRstN   (coreRstN),
    .resumeRstN (resumeRstN),
    .rtcRstN    (rtcRstN),
    .tmrOvf     (tmrOvf),
    .gblEvt     (gblEvt),
    .pwrBtn     (pwrBtn),
    .rtcAlarm   (rtcAlarm),
    .sciEnable  (sciEnable),
    .inS0       (state == PWR_ON),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWData   (regWData),
    .strobe     (strobe),
    .regRData   (regRData),
    .statusVec  (statusVec),
    .sciOut     (sciOut),
    .smiOut     (smiOut),
    .wakeCand   (wakeCand),
    .afterLoss  (afterLoss)
  );

  pmev_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk        (clk),
    .resumeRstN (resumeRstN),
    .rtcRstN    (rtcRstN),
    .pwrBtn     (pwrBtn),
    .sleepReq   (sleepReq),
    .wakeCand   (wakeCand),
    .afterLoss  (afterLoss),
    .strobe     (strobe),
    .state      (state),
    .wakeEvent  (wakeEvent)
  );

  assign sysState = state;

endmodule

// File: rtl/pmev_chk.sv
module pmev_chk (
  input logic        clk,
  input logic        coreRstN,
  input logic        resumeRstN,
  input logic        rtcRstN,
  input logic        sciEnable,
  input logic        sciOut,
  input logic        smiOut,
  input logic        wakeEvent,
  input logic [1:0]  sysState,
  input logic [15:0] statusVec
);

  logic anyRst;
  assign anyRst = !coreRstN || !resumeRstN || !rtcRstN;

  // R5
  route_sci_chk: assert property (@(posedge clk) disable iff (anyRst)
    sciOut |-> sciEnable);

  // R5
  route_smi_chk: assert property (@(posedge clk) disable iff (anyRst)
    smiOut |-> !sciEnable);

  // R6
  asleep_quiet_chk: assert property (@(posedge clk) disable iff (anyRst)
    (sysState != 2'b00) |-> (!sciOut && !smiOut));

  // R7
  wake_resume_chk: assert property (@(posedge clk) disable iff (anyRst)
    wakeEvent |=> (sysState == 2'b00 && statusVec[15]));

  // R7
  wake_cause_chk: assert property (@(posedge clk) disable iff (anyRst)
    $rose(statusVec[15]) |-> $past(wakeEvent));

  // R8
  override_off_chk: assert property (@(posedge clk) disable iff (anyRst)
    $rose(statusVec[11]) |-> (sysState == 2'b10));

endmodule

bind pmev_top pmev_chk chkInst (
  .clk        (clk),
  .coreRstN   (coreRstN),
  .resumeRstN (resumeRstN),
  .rtcRstN    (rtcRstN),
  .sciEnable  (sciEnable),
  .sciOut     (sciOut),
  .smiOut     (smiOut),
  .wakeEvent  (wakeEvent),
  .sysState   (sysState),
  .statusVec  (statusVec)
);

// File: tb/pmev_top_test.sv
`timescale 1ns/100ps
module pmev_top_test;

  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        coreRstN = 1'b0, resumeRstN = 1'b0, rtcRstN = 1'b0;
  logic        tmrOvf = 1'b0, gblEvt = 1'b0, pwrBtn = 1'b0, rtcAlarm = 1'b0;
  logic        sleepReq = 1'b0, sciEnable = 1'b0;
  logic        regWr = 1'b0, regAddr = 1'b0;
  logic [15:0] regWData = '0;
  logic [15:0] regRData;
  logic        sciOut, smiOut, wakeEvent;
  logic [1:0]  sysState;

  always #2.5 clk = ~clk;

  pmev_top #(.REG_W(16), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .coreRstN(coreRstN), .resumeRstN(resumeRstN), .rtcRstN(rtcRstN),
    .tmrOvf(tmrOvf), .gblEvt(gblEvt), .pwrBtn(pwrBtn), .rtcAlarm(rtcAlarm),
    .sleepReq(sleepReq), .sciEnable(sciEnable), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .sciOut(sciOut), .smiOut(smiOut),
    .wakeEvent(wakeEvent), .sysState(sysState)
  );

  // selectors: 0 status, 1 enable, 2 state, 3 sci, 4 smi, 5 wake
  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (q.size() != 0);
      #0.1;
      begin
        item_t it;
        logic [15:0] obs;
        it = q.pop_front();
        case (it.sel)
          0, 1:    obs = regRData;
          2:       obs = {14'd0, sysState};
          3:       obs = {15'd0, sciOut};
          4:       obs = {15'd0, smiOut};
          default: obs = {15'd0, wakeEvent};
        endcase
        checks++;
        if (obs !== it.exp) begin
          failures++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, obs, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int sel, logic [15:0] exp, string tag);
    item_t it;
    if (sel == 0) regAddr = 1'b0;
    if (sel == 1) regAddr = 1'b1;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic a, logic [15:0] d);
    regAddr = a; regWData = d; regWr = 1'b1;
    tick(1);
    regWr = 1'b0;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    tick(3);
    coreRstN = 1; resumeRstN = 1; rtcRstN = 1;
    // R1 reset state
    expect_val(0, 16'h0000, "R1 status");
    expect_val(1, 16'h0000, "R1 enable");
    expect_val(2, 16'h0000, "R1 state");
    expect_val(3, 16'h0000, "R1 sci");
    expect_val(4, 16'h0000, "R1 smi");
    expect_val(5, 16'h0000, "R1 wake");

    // R4 writable enable bits
    wr_reg(1, 16'hFFFF);
    expect_val(1, 16'h4521, "R4 enable mask");
    wr_reg(1, 16'h0521);
    expect_val(1, 16'h0521, "R4 enable write");

    // R3 / R5 timer event and routing
    sciEnable = 1;
    tmrOvf = 1; tick(1); tmrOvf = 0;
    expect_val(0, 16'h0001, "R3 timer bit");
    expect_val(3, 16'h0001, "R5 sci raised");
    expect_val(4, 16'h0000, "R5 smi quiet");
    sciEnable = 0;
    expect_val(3, 16'h0000, "R5 sci off when routed smi");
    expect_val(4, 16'h0001, "R5 smi raised");

    // R2 write-one-clear
    wr_reg(0, 16'hFFFE);
    expect_val(0, 16'h0001, "R2 zero write keeps");
    wr_reg(0, 16'h0001);
    expect_val(0, 16'h0000, "R2 one write clears");
    expect_val(4, 16'h0000, "R5 smi level drops");

    // R3 / R5 global event never raises smi
    gblEvt = 1; tick(1); gblEvt = 0;
    expect_val(0, 16'h0020, "R3 global bit");
    expect_val(4, 16'h0000, "R5 global no smi");
    sciEnable = 1;
    expect_val(3, 16'h0001, "R5 global sci");
    wr_reg(0, 16'h0020);
    expect_val(0, 16'h0000, "R2 clear global");

    // R2 set wins over clear
    tmrOvf = 1; regAddr = 0; regWData = 16'h0001; regWr = 1;
    tick(1);
    tmrOvf = 0; regWr = 0;
    expect_val(0, 16'h0001, "R2 set beats clear");
    wr_reg(0, 16'h0001);

    // R6 sleep entry quiets interrupts
    tmrOvf = 1; tick(1); tmrOvf = 0;
    expect_val(3, 16'h0001, "R5 sci before sleep");
    sleepReq = 1; tick(1); sleepReq = 0;
    expect_val(2, 16'h0001, "R6 sleeping");
    expect_val(3, 16'h0000, "R6 sci quiet asleep");
    sciEnable = 0;
    expect_val(4, 16'h0000, "R6 smi quiet asleep");
    sciEnable = 1;

    // R7 enabled alarm wakes
    rtcAlarm = 1;
    expect_val(5, 16'h0001, "R7 wake pulse");
    tick(1);
    expect_val(0, 16'h8401, "R7 wake status");
    expect_val(2, 16'h0000, "R7 back running");
    expect_val(5, 16'h0000, "R7 wake pulse ends");
    expect_val(3, 16'h0001, "R5 sci after wake");
    rtcAlarm = 0;
    wr_reg(0, 16'hFFFF);
    expect_val(0, 16'h0000, "R2 clear all");

    // R7 disabled alarm does not wake, enabled button does
    wr_reg(1, 16'h0121);
    sleepReq = 1; tick(1); sleepReq = 0;
    rtcAlarm = 1;
    expect_val(5, 16'h0000, "R7 disabled no wake");
    tick(1);
    rtcAlarm = 0;
    expect_val(0, 16'h0400, "R7 disabled sets status");
    expect_val(2, 16'h0001, "R7 stays asleep");
    pwrBtn = 1;
    expect_val(5, 16'h0001, "R7 button wake pulse");
    tick(1);
    pwrBtn = 0;
    expect_val(0, 16'h8500, "R7 button wake status");
    expect_val(2, 16'h0000, "R7 button back running");
    wr_reg(0, 16'hFFFF);

    // R8 short hold restarts
    wr_reg(1, 16'h0521);
    pwrBtn = 1; tick(HOLD - 1); pwrBtn = 0; tick(1);
    expect_val(0, 16'h0100, "R8 short hold no override");
    expect_val(2, 16'h0000, "R8 short hold running");
    wr_reg(0, 16'hFFFF);

    // R8 full hold
    pwrBtn = 1; tick(HOLD - 1);
    expect_val(2, 16'h0000, "R8 one edge before override");
    tick(1);
    expect_val(0, 16'h0900, "R8 override status");
    expect_val(2, 16'h0002, "R8 soft-off");
    expect_val(1, 16'h4521, "R8 after-loss flag");
    pwrBtn = 0; tick(1);
    expect_val(3, 16'h0000, "R6 sci quiet soft-off");

    // R7 wake from soft-off
    pwrBtn = 1;
    expect_val(5, 16'h0001, "R7 wake from soft-off");
    tick(1);
    pwrBtn = 0;
    expect_val(2, 16'h0000, "R7 soft-off to running");
    expect_val(0, 16'h8900, "R7 soft-off wake status");

    // R9 core reset
    tmrOvf = 1; tick(1); tmrOvf = 0;
    sleepReq = 1; tick(1); sleepReq = 0;
    expect_val(0, 16'h8901, "R9 before core reset");
    coreRstN = 0; tick(1); coreRstN = 1;
    expect_val(0, 16'h8900, "R9 core reset status");
    expect_val(1, 16'h4500, "R9 core reset enable");
    expect_val(2, 16'h0001, "R9 state kept");

    // R10 resume reset with after-loss flag set
    resumeRstN = 0; tick(1); resumeRstN = 1;
    expect_val(0, 16'h0800, "R10 resume status");
    expect_val(1, 16'h4000, "R10 resume enable");
    expect_val(2, 16'h0002, "R10 soft-off after loss");
    wr_reg(1, 16'h4400);
    rtcAlarm = 1;
    expect_val(5, 16'h0001, "R10 later wake pulse");
    tick(1);
    rtcAlarm = 0;
    expect_val(2, 16'h0000, "R10 later wake running");
    expect_val(0, 16'h8C00, "R10 later wake sets bit15");
    wr_reg(1, 16'h0000);
    resumeRstN = 0; tick(1); resumeRstN = 1;
    expect_val(2, 16'h0000, "R10 running without flag");
    expect_val(0, 16'h0800, "R10 bit11 survives");

    // R11 clock-battery reset
    wr_reg(1, 16'h4000);
    rtcRstN = 0; tick(1); rtcRstN = 1;
    expect_val(0, 16'h0000, "R11 status");
    expect_val(1, 16'h0000, "R11 enable");
    expect_val(2, 16'h0000, "R11 state");

    done = 1;
    report();
    $finish;
  end

endmodule